// File: doc/BRIEF.md
# Byte-Wide SPI Port With Master and Slave Roles

This block moves one byte at a time over a four-wire synchronous serial link. The host sees a single buffer: a write loads the byte to send, and after a transfer the same location holds the byte that came in. One hidden shift register does both jobs. The bit leaving on the serial output makes room for the bit entering from the serial input, so eight shifts exchange a whole byte.

A three-bit mode field picks the role. Three codes make the block a master that generates the serial clock from the system clock by 4, 16 or 64. The other codes make it a slave that follows an external clock. In one slave code an active-low select input gates the slave. In the other the select input is ignored. Clock polarity, clock phase and (for the master) the input sample point are separate controls.

Status comes back as a buffer-full flag, a sticky write-collision flag, a sticky receive-overflow flag and a one-cycle completion pulse.

Top module: `spi_port`

## Requirements
- R1: In a master mode a write while idle starts the transfer on the next clock. The master makes 16 clock transitions, each held for D/2 system clocks. D is 4, 16 or 64 for mode codes 0, 1 and 2.
- R2: Data are exchanged most significant bit first. The serial output shows bit 7 of the written byte first, and each later bit appears as the previous one is retired.
- R3: While idle the serial clock rests at the polarity level. With phase 0 the first transition samples and the second launches. With phase 1 the first transition launches and the second samples. In a master, sck_o equals polarity XOR phase XOR (half-period index mod 2) during a transfer.
- R4: In master mode with smp low, the input is captured at the middle of each bit. With smp high, it is captured at the end of each bit.
- R5: When the eighth bit completes and the buffer is empty, the received byte is placed in the buffer and buf_full rises. done is high for exactly one clock.
- R6: A read (rd_en) clears buf_full on the following clock.
- R7: A write during an active transfer changes nothing in the transfer and sets wcol. wcol stays set until wcol_clr is pulsed.
- R8: If a byte completes while buf_full is set and no read occurs, rov sets and the buffer keeps its previous byte. rov stays set until rov_clr is pulsed.
- R9: In slave mode (code 3 with select low, or code 4 with any select level) a write preloads the byte. The external serial clock then exchanges it with the incoming byte. In code 4 the select input has no effect.
- R10: In mode code 3 a high select level disables the serial output driver (sdo_oe low) and discards any partly received bits. A later full frame is then received intact.
- R11: In master modes sdo_oe is always high.
- R12: After reset, buf_full, wcol, rov and done are low and sck_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | 0/1/2 master at clk/4, /16, /64; 3 slave with select; 4 slave without select |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase: 0 samples on first transition, 1 launches on first transition |
| smp | input | 1 | Master sample point: 0 mid-bit, 1 end of bit; keep low in slave modes |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | DATA_W | Byte to transmit |
| rd_en | input | 1 | Buffer read strobe |
| rd_data | output | DATA_W | Last accepted received byte |
| buf_full | output | 1 | Received byte waiting to be read |
| wcol | output | 1 | Sticky write-collision flag |
| rov | output | 1 | Sticky receive-overflow flag |
| wcol_clr | input | 1 | Clears wcol |
| rov_clr | input | 1 | Clears rov |
| done | output | 1 | One-clock pulse per completed byte |
| sck_o | output | 1 | Serial clock driven in master modes |
| sck_i | input | 1 | External serial clock for slave modes |
| ss_n_i | input | 1 | Active-low slave select |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo_o |

## Verification
In master modes the bench compares sck_o, sdo_o, the flags and the buffer against a behavioural model on every clock. The bench drives a different input bit in each half of every bit time. A design that samples at the wrong point therefore receives a different byte, and a design with the wrong divider or phase shows a clock mismatch within one half period. A second write during a transfer checks that a design which restarts or reloads is caught by sdo_o. Completion into an unread buffer checks that a design which overwrites the buffer fails the overflow check. In slave mode the bench acts as the external master under both phases and both polarities, and with the select input high where it must be ignored. A partial frame followed by deselect checks that a design keeping a stale bit count finishes early with the wrong byte.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_MST_D4   = 3'd0,
    MODE_MST_D16  = 3'd1,
    MODE_MST_D64  = 3'd2,
    MODE_SLV_SEL  = 3'd3,
    MODE_SLV_FREE = 3'd4
  } spi_mode_e;

  function automatic logic mode_is_master(input logic [MODE_W-1:0] m);
    return m < MODE_SLV_SEL;
  endfunction

  function automatic logic mode_uses_select(input logic [MODE_W-1:0] m);
    return m == MODE_SLV_SEL;
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  // Plain tracking flops: no reset, so a settled input never yields a false edge after reset.
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) stg[0] <= din;

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) stg[i] <= stg[i-1];
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_master_eng.sv
module spi_master_eng #(
  parameter int DATA_W    = 8,
  parameter int BASE_HALF = 2,
  parameter int STEP_LOG2 = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] div_sel,
  input  logic       cpol,
  input  logic       cpha,
  input  logic       smp,
  input  logic       sdi,
  output logic       busy,
  output logic       sck,
  output logic       shift_req,
  output logic       shift_bit,
  output logic       last
);
  localparam int HP_N     = 2 * DATA_W;
  localparam int HP_W     = $clog2(HP_N);
  localparam int MAX_HALF = BASE_HALF << (2 * STEP_LOG2);
  localparam int TK_W     = $clog2(MAX_HALF) + 1;

  logic [HP_W-1:0] hp;
  logic [TK_W-1:0] tick, half_m1;
  logic            held, bnd, fin;
  int              half_i;

  always_comb begin
    half_i  = BASE_HALF << (STEP_LOG2 * int'(div_sel));
    half_m1 = TK_W'(half_i - 1);
  end

  assign bnd       = busy && (tick == half_m1);
  assign fin       = bnd && (hp == HP_W'(HP_N - 1));
  assign shift_req = bnd && hp[0];
  assign shift_bit = smp ? sdi : held;
  assign last      = fin;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      hp   <= '0;
      tick <= '0;
      sck  <= 1'b0;
      held <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      hp   <= '0;
      tick <= '0;
      sck  <= cpol ^ cpha;
    end else if (busy) begin
      if (bnd) begin
        tick <= '0;
        if (!hp[0] && !smp) held <= sdi;
        if (fin) begin
          busy <= 1'b0;
          sck  <= cpol;
        end else begin
          hp  <= hp + 1'b1;
          sck <= cpol ^ cpha ^ ~hp[0];
        end
      end else begin
        tick <= tick + 1'b1;
      end
    end else begin
      sck <= cpol;
    end
  end

  a_r3_idle_level: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> (sck == $past(cpol)));

  a_r1_stops_after_last: assert property (@(posedge clk) disable iff (rst)
    last |=> !busy);
endmodule

// File: rtl/spi_slave_eng.sv
module spi_slave_eng #(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic use_ss,
  input  logic cpol,
  input  logic cpha,
  input  logic sck_s,
  input  logic ss_s,
  input  logic sdi_s,
  output logic active,
  output logic desel,
  output logic shift_req,
  output logic shift_bit,
  output logic last
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0] nsamp;
  logic             sck_d, held;
  logic             rise, fall, lead, trail, s_e, l_e, go, fin_a, fin_b;

  always_ff @(posedge clk) sck_d <= sck_s;

  assign rise   = sck_s & ~sck_d;
  assign fall   = ~sck_s & sck_d;
  assign lead   = cpol ? fall : rise;
  assign trail  = cpol ? rise : fall;
  assign s_e    = cpha ? trail : lead;
  assign l_e    = cpha ? lead : trail;
  assign desel  = use_ss & ss_s;
  assign go     = en & ~desel;
  assign fin_a  = l_e & ~cpha & (nsamp == CNT_W'(DATA_W));
  assign fin_b  = s_e & cpha & (nsamp == CNT_W'(DATA_W - 1));
  assign active = (nsamp != '0);

  assign shift_req = go & ((l_e & active) | fin_b);
  assign shift_bit = l_e ? held : sdi_s;
  assign last      = go & (fin_a | fin_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      nsamp <= '0;
      held  <= 1'b0;
    end else if (!go) begin
      nsamp <= '0;
    end else if (s_e) begin
      held  <= sdi_s;
      nsamp <= fin_b ? '0 : nsamp + 1'b1;
    end else if (fin_a) begin
      nsamp <= '0;
    end
  end

  a_r10_desel_clears: assert property (@(posedge clk) disable iff (rst)
    (desel && en) |=> (nsamp == '0));
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              active,
  input  logic              rd_en,
  input  logic              last,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              wcol_clr,
  input  logic              rov_clr,
  output logic [DATA_W-1:0] rx_buf,
  output logic              full,
  output logic              wcol,
  output logic              rov,
  output logic              done
);
  logic lose;
  assign lose = last && full && !rd_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_buf <= '0;
      full   <= 1'b0;
      wcol   <= 1'b0;
      rov    <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= last;
      if (last) begin
        if (!lose) begin
          rx_buf <= byte_in;
          full   <= 1'b1;
        end
      end else if (rd_en) begin
        full <= 1'b0;
      end
      if (lose)          rov <= 1'b1;
      else if (rov_clr)  rov <= 1'b0;
      if (wr_en && active) wcol <= 1'b1;
      else if (wcol_clr)   wcol <= 1'b0;
    end
  end

  a_r7_wcol_sticky: assert property (@(posedge clk) disable iff (rst)
    (wcol && !wcol_clr) |=> wcol);

  a_r7_wcol_sets: assert property (@(posedge clk) disable iff (rst)
    (wr_en && active) |=> wcol);

  a_r8_keep_old: assert property (@(posedge clk) disable iff (rst)
    lose |=> ($stable(rx_buf) && full && rov));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !last) |=> !full);

  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BASE_HALF   = 2,
  parameter int STEP_LOG2   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              smp,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              buf_full,
  output logic              wcol,
  output logic              rov,
  input  logic              wcol_clr,
  input  logic              rov_clr,
  output logic              done,
  output logic              sck_o,
  input  logic              sck_i,
  input  logic              ss_n_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe
);
  logic              is_master, use_ss;
  logic              sck_s, ss_s, sdi_s;
  logic              m_busy, m_shift, m_bit, m_last;
  logic              s_active, s_desel, s_shift, s_bit, s_last;
  logic              xfer_active, accept, shift_req, shift_bit, last;
  logic [DATA_W-1:0] sr, done_byte;

  assign is_master = mode_is_master(mode);
  assign use_ss    = mode_uses_select(mode);

  spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .din  ({sck_i, ss_n_i, sdi_i}),
    .dout ({sck_s, ss_s, sdi_s})
  );

  assign xfer_active = m_busy | s_active;
  assign accept      = wr_en & ~xfer_active;

  spi_master_eng #(.DATA_W(DATA_W), .BASE_HALF(BASE_HALF), .STEP_LOG2(STEP_LOG2)) u_mst (
    .clk       (clk),
    .rst       (rst),
    .start     (accept & is_master),
    .div_sel   (mode[1:0]),
    .cpol      (cpol),
    .cpha      (cpha),
    .smp       (smp),
    .sdi       (sdi_i),
    .busy      (m_busy),
    .sck       (sck_o),
    .shift_req (m_shift),
    .shift_bit (m_bit),
    .last      (m_last)
  );

  spi_slave_eng #(.DATA_W(DATA_W)) u_slv (
    .clk       (clk),
    .rst       (rst),
    .en        (~is_master),
    .use_ss    (use_ss),
    .cpol      (cpol),
    .cpha      (cpha),
    .sck_s     (sck_s),
    .ss_s      (ss_s),
    .sdi_s     (sdi_s),
    .active    (s_active),
    .desel     (s_desel),
    .shift_req (s_shift),
    .shift_bit (s_bit),
    .last      (s_last)
  );

  assign shift_req = is_master ? m_shift : s_shift;
  assign shift_bit = is_master ? m_bit   : s_bit;
  assign last      = is_master ? m_last  : s_last;
  assign done_byte = {sr[DATA_W-2:0], shift_bit};

  always_ff @(posedge clk) begin
    if (rst)            sr <= '0;
    else if (accept)    sr <= wr_data;
    else if (shift_req) sr <= done_byte;
  end

  assign sdo_o  = sr[DATA_W-1];
  assign sdo_oe = is_master | ~s_desel;

  spi_host_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .active   (xfer_active),
    .rd_en    (rd_en),
    .last     (last),
    .byte_in  (done_byte),
    .wcol_clr (wcol_clr),
    .rov_clr  (rov_clr),
    .rx_buf   (rd_data),
    .full     (buf_full),
    .wcol     (wcol),
    .rov      (rov),
    .done     (done)
  );

  a_r2_load_msb: assert property (@(posedge clk) disable iff (rst)
    accept |=> (sdo_o == $past(wr_data[DATA_W-1])));

  a_r11_master_drives: assert property (@(posedge clk) disable iff (rst)
    is_master |-> sdo_oe);
endmodule

// File: tb/tb_spi_port.sv
module tb_spi_port;
  localparam int CLK_P = 10;
  localparam int SH    = 8;

  logic       clk = 1'b0, rst = 1'b1;
  logic [2:0] mode = 3'd0;
  logic       cpol = 1'b0, cpha = 1'b0, smp = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, wcol_clr = 1'b0, rov_clr = 1'b0;
  logic [7:0] wr_data = 8'h00, rd_data;
  logic       buf_full, wcol, rov, done, sck_o, sdo_o, sdo_oe;
  logic       sck_t = 1'b0, ss_t = 1'b0, sdi_t = 1'b0, sdi_m = 1'b0;
  logic       model_on = 1'b1;
  logic       sdi_i;

  assign sdi_i = model_on ? sdi_m : sdi_t;

  always #(CLK_P/2) clk = ~clk;

  spi_port dut (
    .clk(clk), .rst(rst), .mode(mode), .cpol(cpol), .cpha(cpha), .smp(smp),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .buf_full(buf_full), .wcol(wcol), .rov(rov), .wcol_clr(wcol_clr), .rov_clr(rov_clr),
    .done(done), .sck_o(sck_o), .sck_i(sck_t), .ss_n_i(ss_t), .sdi_i(sdi_i),
    .sdo_o(sdo_o), .sdo_oe(sdo_oe)
  );

  int  n_chk = 0, n_fail = 0;
  bit  finished = 0;

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural master-mode reference
  int         mt = 0, H = 2;
  bit         m_busy = 0, m_full = 0, m_wcol = 0, m_rov = 0, m_done = 0;
  logic [7:0] m_tx = 0, m_buf = 0, patA = 0, patB = 0;
  logic       c_cpol = 0, c_cpha = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_full = 0; m_wcol = 0; m_rov = 0; m_done = 0; mt = 0; m_buf = 0;
      c_cpol = 0; c_cpha = 0;
    end else if (model_on) begin
      bit b0, comp;
      b0 = m_busy; comp = 0;
      c_cpol = cpol; c_cpha = cpha;
      H = 2 << (2 * int'(mode));
      if (m_busy) begin
        mt++;
        if (mt == 16 * H) begin m_busy = 0; comp = 1; end
      end
      if (wr_en && b0) m_wcol = 1;
      else if (wcol_clr) m_wcol = 0;
      if (wr_en && !b0) begin m_busy = 1; mt = 0; m_tx = wr_data; end
      if (comp) begin
        if (m_full && !rd_en) m_rov = 1;
        else begin m_buf = smp ? patB : patA; m_full = 1; end
      end else if (rd_en) m_full = 0;
      if (!(comp && m_full && !rd_en) && rov_clr) m_rov = 0;
      m_done = comp;
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst) begin
      int hp;
      hp = mt / H;
      chk_eq("R1/R3 sck_o", sck_o, m_busy ? (c_cpol ^ c_cpha ^ hp[0]) : c_cpol);
      if (m_busy) chk_eq("R2 sdo_o", sdo_o, m_tx[7 - hp/2]);
      chk_eq("R5 buf_full", buf_full, m_full);
      if (m_full) chk_eq("R5 rd_data", rd_data, m_buf);
      chk_eq("R7 wcol", wcol, m_wcol);
      chk_eq("R8 rov", rov, m_rov);
      chk_eq("R5 done", done, m_done);
      chk_eq("R11 sdo_oe", sdo_oe, 1'b1);
      sdi_m = m_busy ? ((hp % 2 == 0) ? patA[7 - hp/2] : patB[7 - hp/2]) : 1'b0;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_wr(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse_wclr();
    @(negedge clk); wcol_clr = 1'b1;
    @(negedge clk); wcol_clr = 1'b0;
  endtask

  task automatic pulse_rclr();
    @(negedge clk); rov_clr = 1'b1;
    @(negedge clk); rov_clr = 1'b0;
  endtask

  task automatic slave_setup(input logic [2:0] m, input logic p, input logic h, input logic s);
    @(negedge clk);
    model_on = 1'b0; mode = m; cpol = p; cpha = h; smp = 1'b0;
    sck_t = p; ss_t = s; sdi_t = 1'b0; rst = 1'b1;
    cyc(5);
    rst = 1'b0;
    cyc(2);
  endtask

  // Bench acts as external master; returns the bits seen on sdo_o
  task automatic sl_frame(input logic [7:0] mb, input int nbits, output logic [7:0] got);
    got = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      if (!cpha) begin
        sdi_t = mb[7-i];
        cyc(SH);
        got[7-i] = sdo_o;
        sck_t = ~sck_t;
        cyc(SH);
        sck_t = ~sck_t;
      end else begin
        sck_t = ~sck_t;
        sdi_t = mb[7-i];
        cyc(SH);
        got[7-i] = sdo_o;
        sck_t = ~sck_t;
        cyc(SH);
      end
    end
    cyc(6);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    logic [7:0] got;
    cyc(5);
    rst = 1'b0;
    cyc(1);
    // R12 reset state
    chk_eq("R12 buf_full", buf_full, 1'b0);
    chk_eq("R12 wcol", wcol, 1'b0);
    chk_eq("R12 rov", rov, 1'b0);
    chk_eq("R12 done", done, 1'b0);
    chk_eq("R12 sck_o", sck_o, 1'b0);

    // Master /4, idle low, phase 0, mid-bit sample
    patA = 8'h3C; patB = 8'hC3;
    pulse_wr(8'hA5);
    cyc(40);
    chk_eq("R4 mid sample byte", rd_data, 8'h3C);
    chk_eq("R5 full after byte", buf_full, 1'b1);
    pulse_rd();
    chk_eq("R6 read clears full", buf_full, 1'b0);

    // Master /16, idle high, phase 1, end sample, with a colliding write
    mode = 3'd1; cpol = 1'b1; cpha = 1'b1; smp = 1'b1;
    cyc(2);
    pulse_wr(8'h5A);
    cyc(20);
    pulse_wr(8'hFF);
    chk_eq("R7 wcol after collision", wcol, 1'b1);
    cyc(120);
    chk_eq("R4 end sample byte", rd_data, 8'hC3);
    cyc(4);
    chk_eq("R7 wcol still set", wcol, 1'b1);
    pulse_wclr();
    chk_eq("R7 wcol cleared", wcol, 1'b0);

    // Master /64 into an unread buffer -> overflow
    mode = 3'd2; cpol = 1'b0; cpha = 1'b1; smp = 1'b0;
    patA = 8'h69; patB = 8'h96;
    cyc(2);
    pulse_wr(8'h24);
    cyc(16 * 32 + 6);
    chk_eq("R8 rov set", rov, 1'b1);
    chk_eq("R8 buffer kept", rd_data, 8'hC3);
    pulse_rclr();
    chk_eq("R8 rov cleared", rov, 1'b0);
    pulse_rd();

    // Master /4, idle high, phase 0, end sample
    mode = 3'd0; cpol = 1'b1; cpha = 1'b0; smp = 1'b1;
    patA = 8'hF0; patB = 8'h0F;
    cyc(2);
    pulse_wr(8'hE7);
    cyc(40);
    chk_eq("R4 end sample byte 2", rd_data, 8'h0F);

    // Slave without select, phase 0, idle low
    slave_setup(3'd4, 1'b0, 1'b0, 1'b0);
    pulse_wr(8'h96);
    sl_frame(8'h4B, 8, got);
    chk_eq("R9 slave sent", got, 8'h96);
    chk_eq("R9 slave received", rd_data, 8'h4B);
    chk_eq("R9 slave full", buf_full, 1'b1);

    // Slave without select, phase 1, idle high, select held high (no effect)
    slave_setup(3'd4, 1'b1, 1'b1, 1'b1);
    pulse_wr(8'h3E);
    sl_frame(8'hD2, 8, got);
    chk_eq("R9 slave sent ph1", got, 8'h3E);
    chk_eq("R9 slave received ph1", rd_data, 8'hD2);
    chk_eq("R9 select ignored oe", sdo_oe, 1'b1);

    // Slave with select: partial frame, deselect, full frame
    slave_setup(3'd3, 1'b0, 1'b1, 1'b0);
    pulse_wr(8'h11);
    sl_frame(8'hFF, 3, got);
    pulse_wr(8'h22);
    chk_eq("R7 slave collision", wcol, 1'b1);
    ss_t = 1'b1;
    cyc(5);
    chk_eq("R10 output released", sdo_oe, 1'b0);
    chk_eq("R10 no byte on deselect", buf_full, 1'b0);
    ss_t = 1'b0;
    cyc(5);
    chk_eq("R10 output driven", sdo_oe, 1'b1);
    sl_frame(8'h77, 8, got);
    chk_eq("R10 fresh frame byte", rd_data, 8'h77);
    chk_eq("R10 fresh frame full", buf_full, 1'b1);

    report();
  end
endmodule